// File: doc/BRIEF.md
# MDIO Paged Switch Register Bridge

This block lets a local host read and write 32-bit registers inside an Ethernet switch whose only management path is a single Clause 22 MDIO bus. The switch register space is far larger than the 32 registers that one Clause 22 PHY address can reach. The block therefore splits every register byte address into three fields. The top field is a page number, which the block first writes to a dedicated page-select PHY address. The middle three bits travel in the low bits of the PHY address of the data frames. The remaining bits pick the register number. The 32-bit value then moves as two 16-bit frames, lower half first.

The host starts an access by raising `req` for one cycle, together with address, write enable and write data. The block takes over the bus and sends a page frame and two data frames, each preceded by a 32-bit preamble. It then pulses `ack` for one cycle. For reads, the assembled 32-bit word is on `rdata` when `ack` is high. MDC runs only while a frame is on the wire, at a half period of `MDC_HALF` system clocks (10 clocks at 50 MHz gives 2.5 MHz). The MDIO line is split into output, output-enable and input, for a pad tri-state buffer. The bus must carry only this one switch, because the switch answers on PHY addresses 16 to 24.

Top module: `swreg_mdio_bridge`

## Requirements
- R1: After reset, and whenever no access is in progress, `mdc` is low and `mdio_oe` is low. `ack` is low after reset.
- R2: Every frame is exactly 64 MDC periods long: 32 ones, start bits 01, a 2-bit opcode, a 5-bit PHY address and a 5-bit register number, all driven, then turnaround and 16 data bits, sent MSB first. MDC stays high for exactly `MDC_HALF` clocks, and its rising edges within a frame are `2*MDC_HALF` clocks apart.
- R3: The first frame of every access is a write (opcode 01) to PHY address 24, register 0. Its data is the page value `addr[18:9]`, zero-extended to 16 bits.
- R4: Both data frames use PHY address `16 | addr[8:6]`. A register address below 32 is therefore reached at PHY address 16 with page 0.
- R5: A write access sends opcode 01 frames. The first carries `wdata[15:0]` to register `{addr[5:2],0}` and the second carries `wdata[31:16]` to register `{addr[5:2],1}`. The turnaround is driven as 1 then 0.
- R6: A read access sends opcode 10 frames, to register `{addr[5:2],0}` first and then to `{addr[5:2],1}`. `mdio_oe` is low from the first turnaround bit through the last data bit.
- R7: Read data is taken from `mdio_i` on MDC rising edges, MSB first. At `ack`, `rdata` equals `{second frame data, first frame data}`.
- R8: `ack` is high for exactly one clock per accepted request. That clock is the first cycle with MDC low after the final high phase of the third frame.
- R9: A `req` raised while an access is in progress is ignored: it causes no frames and no `ack`. `addr[1:0]` has no effect on any frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | One-cycle access request, taken when idle |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | ADDR_W | Switch register byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid with `ack` on reads |
| ack | output | 1 | One-cycle completion pulse |
| mdc | output | 1 | Management clock |
| mdio_i | input | 1 | MDIO pad input |
| mdio_o | output | 1 | MDIO pad output value |
| mdio_oe | output | 1 | MDIO pad output enable |

## Verification
The bench decodes every frame from the MDC edges and models the switch side. That model keeps its own page register and a memory addressed by page, PHY bits and register, and it returns data on reads. A wrong field split shows up as read data that does not match what the host-side model wrote at the same byte address. The bench uses the highest page, an address below 32, nonzero `addr[1:0]` and an unwritten location. It also raises a request in the middle of a frame, which a design that re-latches the address would answer with corrupted frames or a second `ack`. A design that keeps driving MDIO through the turnaround, samples read data one edge early, or pulses `ack` before the last MDC high phase ends fails the per-frame enable, data or edge-timing checks.

// File: rtl/swreg_mdio_pkg.sv
package swreg_mdio_pkg;

    localparam int HALF_W     = 16;
    localparam int WORD_W     = 2 * HALF_W;
    localparam int PRE_BITS   = 32;
    localparam int FRAME_BITS = 64;
    localparam int TA_IDX     = 46;
    localparam int DATA_IDX   = 48;

    localparam logic [4:0] PAGE_PHY  = 5'h18;
    localparam logic [4:0] DATA_PHY  = 5'h10;
    localparam logic [4:0] PAGE_REG  = 5'h00;
    localparam logic [1:0] OP_WRITE  = 2'b01;
    localparam logic [1:0] OP_READ   = 2'b10;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_PAGE,
        SQ_LO,
        SQ_HI,
        SQ_ACK
    } seq_state_e;

    typedef struct packed {
        logic              rd;
        logic [4:0]        phy;
        logic [4:0]        regad;
        logic [HALF_W-1:0] data;
    } mdio_frame_t;

    function automatic logic [FRAME_BITS-1:0] frame_bits(input mdio_frame_t f);
        logic [1:0] op;
        logic [1:0] ta;
        op = f.rd ? OP_READ : OP_WRITE;
        ta = f.rd ? 2'b11 : 2'b10;
        return {{PRE_BITS{1'b1}}, 2'b01, op, f.phy, f.regad, ta,
                f.rd ? {HALF_W{1'b0}} : f.data};
    endfunction

endpackage

// File: rtl/mdc_divider.sv
module mdc_divider #(
    parameter int MDC_HALF = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic mdc,
    output logic rise_evt,
    output logic fall_evt
);
    localparam int CNT_W = $clog2(MDC_HALF + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(MDC_HALF - 1);

    logic [CNT_W-1:0] cnt;
    logic             wrap;

    assign wrap     = run && (cnt == LAST);
    assign rise_evt = wrap && !mdc;
    assign fall_evt = wrap && mdc;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (wrap) begin
            cnt <= '0;
            mdc <= ~mdc;
        end else if (run) begin
            cnt <= cnt + 1'b1;
        end else begin
            cnt <= '0;
            mdc <= 1'b0;
        end
    end
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
    import swreg_mdio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  mdio_frame_t       frame,
    input  logic              rise_evt,
    input  logic              fall_evt,
    input  logic              mdio_i,
    output logic              busy,
    output logic              done,
    output logic              mdio_o,
    output logic              mdio_oe,
    output logic [HALF_W-1:0] rd_half
);
    localparam logic [5:0] LAST_IDX = 6'(FRAME_BITS - 1);

    logic [FRAME_BITS-1:0] shreg;
    logic [5:0]            idx;
    logic                  rd_q;
    logic                  released;

    assign released = rd_q && (idx >= 6'(TA_IDX));
    assign done     = busy && fall_evt && (idx == LAST_IDX);
    assign mdio_o   = shreg[FRAME_BITS-1];
    assign mdio_oe  = busy && !released;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b0;
            shreg   <= '0;
            idx     <= '0;
            rd_q    <= 1'b0;
            rd_half <= '0;
        end else if (!busy) begin
            if (start) begin
                busy  <= 1'b1;
                shreg <= frame_bits(frame);
                idx   <= '0;
                rd_q  <= frame.rd;
            end
        end else begin
            if (rise_evt && rd_q && (idx >= 6'(DATA_IDX)))
                rd_half <= {rd_half[HALF_W-2:0], mdio_i};
            if (fall_evt) begin
                if (idx == LAST_IDX) begin
                    busy <= 1'b0;
                end else begin
                    idx   <= idx + 1'b1;
                    shreg <= {shreg[FRAME_BITS-2:0], 1'b0};
                end
            end
        end
    end
endmodule

// File: rtl/access_sequencer.sv
module access_sequencer
    import swreg_mdio_pkg::*;
#(
    parameter int ADDR_W = 19
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic              we,
    input  logic [ADDR_W-1:2] addr,
    input  logic [WORD_W-1:0] wdata,
    input  logic              done,
    input  logic [HALF_W-1:0] rd_half,
    output logic              launch,
    output mdio_frame_t       frame,
    output logic              ack,
    output logic [WORD_W-1:0] rdata,
    output seq_state_e        st,
    output logic [ADDR_W-1:2] addr_q
);
    logic              we_q;
    logic [WORD_W-1:0] wdata_q;
    logic [4:0]        data_phy;

    assign data_phy = DATA_PHY | {2'b00, addr_q[8:6]};
    assign ack      = (st == SQ_ACK);

    always_comb begin
        frame = '{rd: 1'b0, phy: PAGE_PHY, regad: PAGE_REG,
                  data: HALF_W'(addr_q[ADDR_W-1:9])};
        case (st)
            SQ_LO: frame = '{rd: !we_q, phy: data_phy,
                             regad: {addr_q[5:2], 1'b0},
                             data: wdata_q[HALF_W-1:0]};
            SQ_HI: frame = '{rd: !we_q, phy: data_phy,
                             regad: {addr_q[5:2], 1'b1},
                             data: wdata_q[WORD_W-1:HALF_W]};
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= SQ_IDLE;
            launch  <= 1'b0;
            we_q    <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
            rdata   <= '0;
        end else begin
            launch <= 1'b0;
            case (st)
                SQ_IDLE: if (req) begin
                    we_q    <= we;
                    addr_q  <= addr;
                    wdata_q <= wdata;
                    st      <= SQ_PAGE;
                    launch  <= 1'b1;
                end
                SQ_PAGE: if (done) begin
                    st     <= SQ_LO;
                    launch <= 1'b1;
                end
                SQ_LO: if (done) begin
                    if (!we_q) rdata[HALF_W-1:0] <= rd_half;
                    st     <= SQ_HI;
                    launch <= 1'b1;
                end
                SQ_HI: if (done) begin
                    if (!we_q) rdata[WORD_W-1:HALF_W] <= rd_half;
                    st <= SQ_ACK;
                end
                default: st <= SQ_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/swreg_mdio_bridge.sv
module swreg_mdio_bridge
    import swreg_mdio_pkg::*;
#(
    parameter int MDC_HALF = 10,
    parameter int ADDR_W   = 19
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output logic              ack,
    output logic              mdc,
    input  logic              mdio_i,
    output logic              mdio_o,
    output logic              mdio_oe
);
    logic              launch;
    mdio_frame_t       frame;
    seq_state_e        seq_st;
    logic [ADDR_W-1:2] seq_addr_q;
    logic              eng_busy;
    logic              eng_done;
    logic [HALF_W-1:0] rd_half;
    logic              rise_evt;
    logic              fall_evt;
    logic              unused_addr_lsb;

    assign unused_addr_lsb = ^addr[1:0];

    access_sequencer #(.ADDR_W(ADDR_W)) u_seq (
        .clk     (clk),
        .rst     (rst),
        .req     (req),
        .we      (we),
        .addr    (addr[ADDR_W-1:2]),
        .wdata   (wdata),
        .done    (eng_done),
        .rd_half (rd_half),
        .launch  (launch),
        .frame   (frame),
        .ack     (ack),
        .rdata   (rdata),
        .st      (seq_st),
        .addr_q  (seq_addr_q)
    );

    mdio_frame_engine u_eng (
        .clk      (clk),
        .rst      (rst),
        .start    (launch),
        .frame    (frame),
        .rise_evt (rise_evt),
        .fall_evt (fall_evt),
        .mdio_i   (mdio_i),
        .busy     (eng_busy),
        .done     (eng_done),
        .mdio_o   (mdio_o),
        .mdio_oe  (mdio_oe),
        .rd_half  (rd_half)
    );

    mdc_divider #(.MDC_HALF(MDC_HALF)) u_div (
        .clk      (clk),
        .rst      (rst),
        .run      (eng_busy),
        .mdc      (mdc),
        .rise_evt (rise_evt),
        .fall_evt (fall_evt)
    );
endmodule

// File: rtl/swreg_mdio_bridge_chk.sv
module swreg_mdio_bridge_chk
    import swreg_mdio_pkg::*;
#(
    parameter int MDC_HALF = 10,
    parameter int ADDR_W   = 19
) (
    input logic              clk,
    input logic              rst,
    input logic              req,
    input logic              ack,
    input logic              mdc,
    input logic              mdio_oe,
    input seq_state_e        seq_st,
    input logic              eng_done,
    input logic [ADDR_W-1:2] addr_q
);
    logic [15:0] hi_cnt;

    always_ff @(posedge clk) begin
        if (rst)      hi_cnt <= '0;
        else if (mdc) hi_cnt <= hi_cnt + 1'b1;
        else          hi_cnt <= '0;
    end

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        (seq_st == SQ_IDLE || seq_st == SQ_ACK) |-> (!mdc && !mdio_oe));

    assert_mdc_high_width_R2: assert property (@(posedge clk) disable iff (rst)
        $fell(mdc) |-> (hi_cnt == 16'(MDC_HALF)));

    assert_ack_single_R8: assert property (@(posedge clk) disable iff (rst)
        ack |=> !ack);

    assert_ack_after_frame_R8: assert property (@(posedge clk) disable iff (rst)
        ack |-> $past(eng_done));

    assert_busy_req_ignored_R9: assert property (@(posedge clk) disable iff (rst)
        (seq_st != SQ_IDLE && req) |=> $stable(addr_q));
endmodule

bind swreg_mdio_bridge swreg_mdio_bridge_chk #(
    .MDC_HALF (MDC_HALF),
    .ADDR_W   (ADDR_W)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .req      (req),
    .ack      (ack),
    .mdc      (mdc),
    .mdio_oe  (mdio_oe),
    .seq_st   (seq_st),
    .eng_done (eng_done),
    .addr_q   (seq_addr_q)
);

// File: tb/sim_swreg_mdio_bridge.sv
`timescale 1ns/1ps
module sim_swreg_mdio_bridge;
    localparam int H = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req = 1'b0;
    logic        we = 1'b0;
    logic [18:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        ack;
    logic        mdc;
    logic        mdio_i = 1'b0;
    logic        mdio_o;
    logic        mdio_oe;

    always #10 clk = ~clk;

    swreg_mdio_bridge #(.MDC_HALF(H), .ADDR_W(19)) u0 (
        .clk(clk), .rst(rst), .req(req), .we(we), .addr(addr),
        .wdata(wdata), .rdata(rdata), .ack(ack), .mdc(mdc),
        .mdio_i(mdio_i), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
    );

    int n_chk = 0;
    int n_bad = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] initv(input logic [17:0] k);
        return k[15:0] ^ {k[17:16], k[17:16], 12'h9C3};
    endfunction

    // expected frame: {rd, phy[4:0], reg[4:0], data[15:0]}
    logic [26:0] expq[$];
    logic [31:0] hmem[int];
    logic [15:0] smem[int];
    logic [9:0]  spage = '0;
    logic [31:0] exp_rdata = '0;
    bit          exp_is_read = 0;
    bit          pending = 0;
    int          frames_in_txn = 0;

    logic [63:0] fb = '0;
    logic [63:0] fo = '0;
    logic [15:0] rd_word = '0;
    bit          prev_mdc = 0;
    int          rc = 0;
    int          hi_run = 0;
    int          since_rise = 0;
    bit          stop_mon = 0;

    function automatic logic [17:0] skey(input logic [9:0] pg, input logic [4:0] phy,
                                         input logic [4:0] rg);
        return {pg, phy[2:0], rg};
    endfunction

    always @(negedge clk) begin
        if (!rst && !stop_mon) begin
            since_rise++;
            if (mdc && !prev_mdc) begin
                automatic int pos = rc % 64;
                if (pos != 0) chk(since_rise == 2*H, "R2 rise spacing", since_rise, 2*H);
                since_rise = 0;
                fb[63-pos] = mdio_o;
                fo[63-pos] = mdio_oe;
                if (pos == 47 && fb[29:28] == 2'b10) begin
                    automatic logic [17:0] k = skey(spage, fb[27:23], fb[22:18]);
                    rd_word = smem.exists(int'(k)) ? smem[int'(k)] : initv(k);
                    mdio_i = rd_word[15];
                end else if (pos >= 48 && pos < 63 && fb[29:28] == 2'b10) begin
                    mdio_i = rd_word[15-(pos-47)];
                end else if (pos == 63) begin
                    automatic logic [26:0] e;
                    automatic string ptag;
                    mdio_i = 1'b0;
                    if (expq.size() == 0) begin
                        chk(0, "R9 unexpected frame", {5'b0, fb[27:23], fb[22:18], 17'b0}, 0);
                    end else begin
                        e = expq.pop_front();
                        ptag = (e[25:21] == 5'd24) ? "R3" : "R4";
                        chk(fb[63:32] == '1 && fo[63:18] == '1, "R2 preamble/header drive",
                            fb[63:32], 32'hFFFF_FFFF);
                        chk(fb[31:30] == 2'b01, "R2 start bits", fb[31:30], 2'b01);
                        if (e[26]) chk(fb[29:28] == 2'b10, "R6 read opcode", fb[29:28], 2'b10);
                        else       chk(fb[29:28] == 2'b01, "R5 write opcode", fb[29:28], 2'b01);
                        chk(fb[27:23] == e[25:21], {ptag, " phy address"}, fb[27:23], e[25:21]);
                        chk(fb[22:18] == e[20:16], {ptag, " register"}, fb[22:18], e[20:16]);
                        if (e[26]) begin
                            chk(fo[17:0] == '0, "R6 released from turnaround", fo[17:0], 0);
                        end else begin
                            chk(fb[17:16] == 2'b10 && fo[17:16] == 2'b11, "R5 turnaround",
                                {fo[17:16], fb[17:16]}, 4'b1110);
                            chk(fb[15:0] == e[15:0], {ptag, " write data"}, fb[15:0], e[15:0]);
                            if (fb[27:23] == 5'd24 && fb[22:18] == 5'd0) spage = fb[9:0];
                            else smem[int'(skey(spage, fb[27:23], fb[22:18]))] = fb[15:0];
                        end
                    end
                    frames_in_txn++;
                end
                rc++;
            end
            if (mdc) hi_run++;
            else begin
                if (prev_mdc) chk(hi_run == H, "R2 MDC high width", hi_run, H);
                hi_run = 0;
            end
            if (ack) begin
                chk(pending, "R8 ack without request", 0, 1);
                chk(prev_mdc && !mdc, "R8 ack position", {prev_mdc, mdc}, 2'b10);
                chk(frames_in_txn == 3 && expq.size() == 0, "R8 ack after third frame",
                    frames_in_txn, 3);
                if (exp_is_read) chk(rdata == exp_rdata, "R7 read data", rdata, exp_rdata);
                pending = 0;
            end
            if (!pending) chk(!mdc && !mdio_oe, "R1 idle lines", {mdc, mdio_oe}, 0);
            prev_mdc = mdc;
        end
    end

    task automatic access(input bit w, input logic [18:0] a, input logic [31:0] d,
                          input bit inject);
        logic [9:0] pg;
        logic [2:0] p3;
        logic [3:0] r4;
        logic [4:0] ph;
        pg = a[18:9]; p3 = a[8:6]; r4 = a[5:2];
        ph = 5'h10 | {2'b00, p3};
        expq.push_back({1'b0, 5'd24, 5'd0, 6'b0, pg});
        expq.push_back({~w, ph, {r4, 1'b0}, d[15:0]});
        expq.push_back({~w, ph, {r4, 1'b1}, d[31:16]});
        if (w) hmem[int'(a[18:2])] = d;
        else exp_rdata = hmem.exists(int'(a[18:2])) ? hmem[int'(a[18:2])] :
                         {initv({pg, p3, r4, 1'b1}), initv({pg, p3, r4, 1'b0})};
        exp_is_read = !w;
        frames_in_txn = 0;
        pending = 1;
        @(negedge clk);
        req = 1'b1; we = w; addr = a; wdata = d;
        @(negedge clk);
        req = 1'b0;
        if (inject) begin
            repeat (500) @(negedge clk);
            req = 1'b1; we = ~w; addr = ~a; wdata = ~d;
            @(negedge clk);
            req = 1'b0;
        end
        while (pending) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        chk(!mdc && !mdio_oe && !ack, "R1 reset state", {mdc, mdio_oe, ack}, 0);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        access(1, 19'h0003C, 32'hDEAD_BEEF, 0);   // R5 write, page 0
        access(0, 19'h0003C, 32'h0, 0);           // R6 R7 read back
        access(0, 19'h00010, 32'h0, 0);           // R4 below 32, unwritten
        access(1, 19'h7FFC7, 32'h1234_5678, 0);   // R3 top page, R9 low bits ignored
        access(0, 19'h7FFC4, 32'h0, 0);           // R7 read across high page
        access(1, 19'h2A1C0, 32'hA5A5_0F0F, 1);   // R9 request while busy
        access(0, 19'h2A1C2, 32'h0, 1);           // R9 read with injected request
        access(0, 19'h15550, 32'h0, 0);           // R7 unwritten location
        access(1, 19'h00000, 32'h0000_FFFF, 0);   // R4 address zero
        access(0, 19'h00000, 32'h0, 0);
        stop_mon = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    int wd = 0;
    always @(posedge clk) begin
        wd++;
        if (wd > 150000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=<150000", wd);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule